// File: doc/BRIEF.md
# Eight-Channel Pulse Width Modulator Bank

This block holds several 8-bit pulse width modulators that share one timebase. A simple write-only register bus programs each channel's duty word and enable flag, plus one global divider value. The divider slows the system clock by N+1. A free-running 8-bit phase counter advances once per divided tick, so every channel runs with the same period.

Each channel has its own small state machine that decides what drives the channel's pin. While the enable flag is clear, the pin is in state `CH_GPIO` and passes the matching general-purpose input straight through. Once the flag is set, the state moves to `CH_HIGH` while the phase is below the active duty and to `CH_LOW` otherwise. The transitions are named as follows:
- `CH_GPIO->CH_HIGH/CH_LOW`: the enable is set.
- `CH_HIGH->CH_LOW`: the phase reaches the duty.
- `CH_LOW->CH_HIGH`: the phase wraps to zero.
- any state `->CH_GPIO`: the enable is cleared.

A duty write goes into a shadow register and is copied to the active duty only when the phase counter wraps. A divider write is copied into the running divider only at the divider's terminal count. Both rules keep partial pulses from appearing.

Top module: `pwm_bank`

## Requirements
- R1: Channel k's duty register is at address 2k and its enable register at 2k+1. The enable uses bit 0 of the write data. The divider value sits at address 2*NUM_CH, which is 16 by default.
- R2: After reset, all enables, duty values and the divider are zero, so every pin follows its general-purpose input.
- R3: A channel whose enable is 0 drives its pin with its general-purpose input in the same cycle.
- R4: An enabled channel with duty D and divider N is high for exactly D*(N+1) of every 256*(N+1) clocks. D=0 keeps the pin low and D=255 gives 255/256.
- R5: A duty of 128 gives a square wave with equal high and low time.
- R6: The PWM period is 256*(N+1) clock cycles for divider value N (0 to 255), and it is the same on all channels.
- R7: A duty written mid-period leaves the current period unchanged. The new value takes effect from the next phase wrap.
- R8: A divider value written mid-count takes effect only at the next divider terminal count.
- R9: Writes to addresses above 2*NUM_CH change no channel output and no period.
- R10: Programming one channel does not change the waveform of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register write address |
| wr_data | input | 8 | Register write data |
| gpio_in | input | NUM_CH (8) | General-purpose values used while a channel is disabled |
| pin_out | output | NUM_CH (8) | Channel pin outputs |

## Verification
The bench builds the block with its default parameters: eight channels, 8-bit duty words and a 5-bit address. With these values the unused addresses 17 to 31 can be written to show that they are ignored. Random divider values are kept between 0 and 3, which limits a period to at most 1024 clocks. That allows many random duty measurements over whole periods, and directed runs at duty 0, 128 and 255. Mid-period duty changes are tested at divider 0, where the position of the phase can be found from the rising edge of the pin.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        CH_GPIO = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2
    } ch_state_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile #(
    parameter int NUM_CH = 8,
    parameter int DUTY_W = 8,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_CH-1:0][DUTY_W-1:0] duty_shadow,
    output logic [NUM_CH-1:0]            ch_en,
    output logic [PRE_W-1:0]             pre_val
);
    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(2 * NUM_CH);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam logic [ADDR_W-1:0] DUTY_A = ADDR_W'(2 * k);
        localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(2 * k + 1);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_shadow[k] <= '0;
                ch_en[k]       <= 1'b0;
            end else if (wr_en) begin
                if (wr_addr == DUTY_A) duty_shadow[k] <= wr_data[DUTY_W-1:0];
                if (wr_addr == EN_A)   ch_en[k]       <= wr_data[0];
            end
        end

        // R1
        en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == EN_A) |=> (ch_en[k] == $past(wr_data[0])));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           pre_val <= '0;
        else if (wr_en && wr_addr == PRE_ADDR) pre_val <= wr_data[PRE_W-1:0];
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int PRE_W   = 8,
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRE_W-1:0]   pre_val,
    output logic [PHASE_W-1:0] phase,
    output logic               wrap
);
    localparam logic [PHASE_W-1:0] PHASE_TOP = '1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_act;
    logic             tick;

    assign tick = (pre_cnt == pre_act);
    assign wrap = tick && (phase == PHASE_TOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            pre_act <= '0;
            phase   <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            pre_act <= pre_val;
            phase   <= phase + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R8
    pre_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pre_act));
    // R6
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= pre_act);
    // R6
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty_shadow,
    input  logic [DUTY_W-1:0] phase,
    input  logic              wrap,
    input  logic              gpio,
    output logic              pin
);
    ch_state_t         state, state_nx;
    logic [DUTY_W-1:0] duty_act;

    always_ff @(posedge clk) begin
        if (!rst_n)    duty_act <= '0;
        else if (wrap) duty_act <= duty_shadow;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_GPIO: if (en) state_nx = (phase < duty_act) ? CH_HIGH : CH_LOW;
            CH_HIGH: if (!en) state_nx = CH_GPIO;
                     else if (phase >= duty_act) state_nx = CH_LOW;
            CH_LOW:  if (!en) state_nx = CH_GPIO;
                     else if (phase < duty_act) state_nx = CH_HIGH;
            default: state_nx = CH_GPIO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_GPIO;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            CH_GPIO: pin = gpio;
            CH_HIGH: pin = 1'b1;
            CH_LOW:  pin = 1'b0;
            default: pin = gpio;
        endcase
    end

    // R7
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(duty_act));
    // R3
    gpio_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == CH_GPIO));
    // R4
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_HIGH) |-> ($past(duty_act) != '0));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
    parameter int NUM_CH = 8,
    parameter int DUTY_W = 8,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] gpio_in,
    output logic [NUM_CH-1:0] pin_out
);
    logic [NUM_CH-1:0][DUTY_W-1:0] duty_shadow;
    logic [NUM_CH-1:0]             ch_en;
    logic [PRE_W-1:0]              pre_val;
    logic [DUTY_W-1:0]             phase;
    logic                          wrap;

    pwm_regfile #(
        .NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .PRE_W(PRE_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .duty_shadow(duty_shadow), .ch_en(ch_en),
        .pre_val(pre_val)
    );

    pwm_timebase #(.PRE_W(PRE_W), .PHASE_W(DUTY_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .pre_val(pre_val),
        .phase(phase), .wrap(wrap)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        pwm_channel #(.DUTY_W(DUTY_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .en(ch_en[k]),
            .duty_shadow(duty_shadow[k]), .phase(phase), .wrap(wrap),
            .gpio(gpio_in[k]), .pin(pin_out[k])
        );
    end
endmodule

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;
    localparam int NCH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [NCH-1:0] gpio_in = '0;
    logic [NCH-1:0] pin_out;

    int checks = 0;
    int fails  = 0;
    int cur_n  = 0;

    pwm_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gpio_in(gpio_in), .pin_out(pin_out)
    );

    always #10 clk = ~clk;

    function automatic int exp_high(int duty, int n);
        return duty * (n + 1);
    endfunction

    function automatic int exp_period(int n);
        return 256 * (n + 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_pre(int n);
        wr(16, n); cur_n = n;
    endtask

    task automatic settle();
        repeat (2 * exp_period(cur_n) + 4) @(negedge clk);
    endtask

    task automatic count_high(int ch, output int cnt);
        cnt = 0;
        for (int i = 0; i < exp_period(cur_n); i++) begin
            @(negedge clk);
            if (pin_out[ch]) cnt++;
        end
    endtask

    task automatic find_rise(int ch);
        int lim = 0;
        @(negedge clk);
        while (pin_out[ch] && lim < 5000) begin @(negedge clk); lim++; end
        while (!pin_out[ch] && lim < 5000) begin @(negedge clk); lim++; end
    endtask

    task automatic rise_gap(int ch, output int gap);
        find_rise(ch);
        gap = 0;
        @(negedge clk); gap++;
        while (pin_out[ch] && gap < 5000) begin @(negedge clk); gap++; end
        while (!pin_out[ch] && gap < 5000) begin @(negedge clk); gap++; end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c, c2, g, d, ch, n;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        gpio_in = 8'hA5;
        @(negedge clk);
        // R2: reset leaves every pin following its GPIO input
        chk("R2 reset pins", int'(pin_out), 'hA5);
        gpio_in = 8'h3C;
        #1;
        // R3: combinational pass-through while disabled
        chk("R3 gpio follow", int'(pin_out), 'h3C);

        // R1 / R4 duty 0 on channel 0, divider 0
        wr(0, 0); wr(1, 1); settle();
        count_high(0, c);
        chk("R4 duty0", c, 0);
        // R5 square wave
        wr(0, 128); settle();
        count_high(0, c);
        chk("R5 half", c, 128);
        // R4 full-scale
        wr(0, 255); settle();
        count_high(0, c);
        chk("R4 duty255", c, 255);

        // R6 period at several divider values
        wr(0, 128);
        for (int i = 0; i < 3; i++) begin
            set_pre(i * 2 + 1); settle();
            rise_gap(0, g);
            chk("R6 period", g, exp_period(cur_n));
        end

        // R8 divider change mid-count
        set_pre(1); settle();
        repeat (3) @(negedge clk);
        set_pre(3); settle();
        rise_gap(0, g);
        chk("R8 new period", g, exp_period(3));

        // R7 mid-period duty write: divider 0, duty 128 running
        set_pre(0); settle();
        find_rise(0);
        repeat (20) @(negedge clk);
        wr(0, 10);
        repeat (60) @(negedge clk);
        chk("R7 hold old duty", int'(pin_out[0]), 1);
        repeat (260) @(negedge clk);
        count_high(0, c);
        chk("R7 new duty", c, 10);

        // R10 two channels at once, one untouched
        wr(4, 64); wr(5, 1); wr(10, 192); wr(11, 1); settle();
        fork
            count_high(2, c);
            count_high(5, c2);
        join
        chk("R10 ch2", c, 64);
        chk("R10 ch5", c2, 192);

        // R9 unmapped writes
        for (int a = 17; a < 32; a++) wr(a, 255);
        settle();
        fork
            count_high(2, c);
            count_high(5, c2);
        join
        chk("R9 ch2 unchanged", c, 64);
        chk("R9 ch5 unchanged", c2, 192);
        rise_gap(5, g);
        chk("R9 period unchanged", g, exp_period(cur_n));

        // R1 enable bit 0 only: data 0xFE disables channel 5
        wr(11, 'hFE);
        repeat (3) @(negedge clk);
        gpio_in = 8'h00; #1;
        chk("R3 disabled ch5 low", int'(pin_out[5]), 0);
        gpio_in = 8'hFF; #1;
        chk("R3 disabled ch5 high", int'(pin_out[5]), 1);

        // Random trials
        for (int t = 0; t < 10; t++) begin
            ch = int'($urandom_range(0, NCH - 1));
            d  = int'($urandom_range(0, 255));
            n  = int'($urandom_range(0, 3));
            set_pre(n);
            wr(2 * ch, d); wr(2 * ch + 1, 1); settle();
            count_high(ch, c);
            chk("R4 random duty", c, exp_high(d, n));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule